// File: doc/BRIEF.md
# Hysteretic Charge Current Gate Modulator

This block drives the single enable line of a battery charge current path. A supervisory controller selects the charge phase. The block turns that phase, together with two digital comparator flags from the current sense path, into the enable level. The sense path is summarised by two flags: sense below the lower threshold (nominally 4 % of supply) and sense above the upper threshold (nominally 5 % of supply). In the continuous fast phase the block acts as a bang-bang regulator with hysteresis. It turns the current on when the sense flag says "below low" and off when it says "above high". Between the thresholds the previous level is held. This lets it regulate a switch-mode inductor current directly. If the sense node is tied to ground, the "below low" flag stays asserted and the enable simply stays high, so the same block can gate an external regulated source.

In the two pulsed phases a timer that counts a prescaled 1 µs tick opens fixed-width enable windows. In the top-off phase the window is 260 ticks out of every 2080 ticks, which gives one eighth of the fast rate. In the trickle phase, which the controller also uses while it waits for the battery to qualify, the window is 260 ticks once per period. A two-bit period code chooses that period. The hysteresis keeps working inside each window, so a pulse never pushes the current past the upper threshold. A phase change restarts the timer at the start of a window. When the phase is off or the inhibit input is asserted, the output is forced low and the timer is cleared.

Top module: `chg_gate_mod`

## Requirements
- R1: When the enable window is open and `sense_lo_i` is 1 while `sense_hi_i` is 0, `chg_en_o` is 1 one clock later.
- R2: When `sense_hi_i` is 1, `chg_en_o` is 0 one clock later.
- R3: In the fast phase, with both sense flags 0, `chg_en_o` keeps its previous value.
- R4: When both sense flags are 1 at once, the upper-threshold flag wins and `chg_en_o` goes to 0.
- R5: In the fast phase with `sense_lo_i` held at 1 (sense node grounded), `chg_en_o` is 1 on every cycle, whatever `tick_i` does.
- R6: In the top-off phase (`phase_i` = 2) the window is open for PULSE_TICKS ticks out of every TOPOFF_TICKS ticks. With the window open, `chg_en_o` is high for exactly that share of cycles in steady state.
- R7: In the trickle phase (`phase_i` = 3) the window is open for PULSE_TICKS ticks. The period is TRICKLE_BASE_TICKS shifted left by `trickle_code_i` (code 0..3), and `chg_en_o` follows the window.
- R8: When `phase_i` = 0 (off) or `inhibit_i` = 1, `chg_en_o` is 0 one clock later and the pulse timer returns to the start of a window.
- R9: On the first cycle of a new pulsed phase, and on the first cycle after inhibit is released, the window is open. With `sense_lo_i` = 1, `chg_en_o` is 1 one clock later.
- R10: Inside a pulsed window the hysteresis still applies: with `sense_lo_i` = 0, or with `sense_hi_i` = 1, no pulse is produced.
- R11: The pulse timer advances only on cycles where `tick_i` = 1. With no ticks, a pulsed phase stays in its first window.
- R12: While `rst_n` is 0, `chg_en_o` is 0.

Phase encoding on `phase_i`: 0 off, 1 fast, 2 top-off, 3 trickle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inhibit_i | input | 1 | Forces the output low and clears the timer |
| phase_i | input | 2 | Charge phase: 0 off, 1 fast, 2 top-off, 3 trickle |
| trickle_code_i | input | 2 | Trickle period select, period = base << code |
| tick_i | input | 1 | Prescaled timing tick, one cycle wide |
| sense_lo_i | input | 1 | Sense voltage is below the lower threshold |
| sense_hi_i | input | 1 | Sense voltage is above the upper threshold |
| chg_en_o | output | 1 | Charge current enable |

## Verification
A hysteresis latch that is stuck or set wrongly shows at `chg_en_o` on the very next clock, because the output is that latch. The vector walk in the fast phase therefore checks each set, clear and hold edge one cycle after its stimulus. A wrong pulse timer (bad period select, a missing wrap, or counting without a tick) shows only as a wrong duty. So the pulsed phases are checked by counting high cycles over whole periods. The first-cycle checks after a phase change or an inhibit release catch a timer that fails to restart.

// File: rtl/cgm_pkg.sv
`timescale 1ns/1ps
package cgm_pkg;

  typedef enum logic [1:0] {
    PH_OFF     = 2'd0,
    PH_FAST    = 2'd1,
    PH_TOPOFF  = 2'd2,
    PH_TRICKLE = 2'd3
  } phase_e;

  // Period of the pulse timer, in ticks, for a pulsed phase.
  function automatic int unsigned pulse_period(phase_e ph, logic [1:0] code,
                                               int unsigned topoff_ticks,
                                               int unsigned base_ticks);
    int unsigned p;
    if (ph == PH_TRICKLE) p = base_ticks << code;
    else                  p = topoff_ticks;
    return p;
  endfunction

  function automatic logic is_pulsed(phase_e ph);
    return (ph == PH_TOPOFF) || (ph == PH_TRICKLE);
  endfunction

  // Bang-bang step: upper threshold wins, lower sets, otherwise hold.
  function automatic logic hyst_step(logic cur, logic lo, logic hi);
    logic n;
    if (hi)      n = 1'b0;
    else if (lo) n = 1'b1;
    else         n = cur;
    return n;
  endfunction

endpackage

// File: rtl/cgm_phase_watch.sv
`timescale 1ns/1ps
module cgm_phase_watch
  import cgm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  phase_e phase,
  output logic   restart
);

  phase_e phase_q;

  // An idle cycle records OFF, so leaving idle always counts as a change.
  always_ff @(posedge clk) begin
    if (!rst_n)   phase_q <= PH_OFF;
    else if (run) phase_q <= phase;
    else          phase_q <= PH_OFF;
  end

  assign restart = run && (phase != phase_q);

endmodule

// File: rtl/cgm_pulse_timer.sv
`timescale 1ns/1ps
module cgm_pulse_timer #(
  parameter int unsigned PULSE_TICKS = 260,
  parameter int unsigned MAX_PERIOD  = 33280,
  parameter int unsigned CW          = 16,
  parameter int unsigned PW          = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic          tick,
  input  logic [PW-1:0] period,
  output logic          win_open
);

  logic [CW-1:0] pos_q;
  logic [CW-1:0] pos_eff;
  logic [CW-1:0] pos_n;
  logic          at_end;

  assign pos_eff  = restart ? '0 : pos_q;
  assign win_open = pos_eff < CW'(PULSE_TICKS);
  // >= so that a period shortened mid-phase still wraps.
  assign at_end   = (PW'(pos_q) + PW'(1)) >= period;

  always_comb begin
    pos_n = pos_q;
    if (!run || restart) pos_n = '0;
    else if (tick)       pos_n = at_end ? '0 : pos_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_n;
  end

  assert_pos_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    PW'(pos_q) < PW'(MAX_PERIOD));

  assert_no_tick_no_move_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && !tick) |=> $stable(pos_q));

  assert_idle_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pos_q == '0));

endmodule

// File: rtl/cgm_hyst_gate.sv
`timescale 1ns/1ps
module cgm_hyst_gate
  import cgm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic lo,
  input  logic hi,
  output logic gate_q
);

  logic gate_n;

  assign gate_n = enable ? hyst_step(gate_q, lo, hi) : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_n;
  end

  assert_set_below_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && lo && !hi) |=> gate_q);

  assert_clear_above_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hi |=> !gate_q);

  assert_hold_between_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !lo && !hi) |=> $stable(gate_q));

  assert_closed_window_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !gate_q);

endmodule

// File: rtl/chg_gate_mod.sv
`timescale 1ns/1ps
module chg_gate_mod
  import cgm_pkg::*;
#(
  parameter int unsigned PULSE_TICKS        = 260,
  parameter int unsigned TOPOFF_TICKS       = 2080,
  parameter int unsigned TRICKLE_BASE_TICKS = 4160
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inhibit_i,
  input  logic [1:0] phase_i,
  input  logic [1:0] trickle_code_i,
  input  logic       tick_i,
  input  logic       sense_lo_i,
  input  logic       sense_hi_i,
  output logic       chg_en_o
);

  localparam int unsigned LONGEST_TRICKLE = TRICKLE_BASE_TICKS * 8;
  localparam int unsigned MAX_PERIOD =
    (TOPOFF_TICKS > LONGEST_TRICKLE) ? TOPOFF_TICKS : LONGEST_TRICKLE;
  localparam int unsigned CW = $clog2(MAX_PERIOD);
  localparam int unsigned PW = CW + 1;

  phase_e        ph;
  logic          run;
  logic          pulsed;
  logic          restart;
  logic          win_open;
  logic          gate_en;
  logic [PW-1:0] period_sel;

  assign ph         = phase_e'(phase_i);
  assign run        = !inhibit_i && (ph != PH_OFF);
  assign pulsed     = is_pulsed(ph);
  assign period_sel = PW'(pulse_period(ph, trickle_code_i,
                                       TOPOFF_TICKS, TRICKLE_BASE_TICKS));

  cgm_phase_watch u_watch (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .phase   (ph),
    .restart (restart)
  );

  cgm_pulse_timer #(
    .PULSE_TICKS (PULSE_TICKS),
    .MAX_PERIOD  (MAX_PERIOD),
    .CW          (CW),
    .PW          (PW)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run && pulsed),
    .restart  (restart),
    .tick     (tick_i),
    .period   (period_sel),
    .win_open (win_open)
  );

  assign gate_en = run && (pulsed ? win_open : 1'b1);

  cgm_hyst_gate u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (gate_en),
    .lo     (sense_lo_i),
    .hi     (sense_hi_i),
    .gate_q (chg_en_o)
  );

  assert_idle_forces_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_i || phase_i == 2'd0) |=> !chg_en_o);

  assert_restart_opens_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && pulsed) |-> win_open);

  assert_grounded_sense_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pulsed && sense_lo_i && !sense_hi_i) |=> chg_en_o);

  assert_pulse_needs_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pulsed && !win_open) |=> !chg_en_o);

endmodule

// File: tb/test_chg_gate_mod.sv
`timescale 1ns/1ps
module test_chg_gate_mod;

  localparam int unsigned PULSE  = 2;
  localparam int unsigned TOPOFF = 16;
  localparam int unsigned TBASE  = 32;

  // {inhibit, phase[1:0], sense_lo, sense_hi, expected output}
  localparam logic [5:0] VEC [12] = '{
    6'b0_01_10_1, 6'b0_01_00_1, 6'b0_01_01_0, 6'b0_01_00_0,
    6'b0_01_10_1, 6'b0_01_11_0, 6'b0_01_10_1, 6'b1_01_10_0,
    6'b0_01_00_0, 6'b0_01_10_1, 6'b0_00_10_0, 6'b0_01_00_0
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       inhibit = 1'b0;
  logic [1:0] phase = 2'd1;
  logic [1:0] tcode = 2'd0;
  logic       tick = 1'b0;
  logic       lo = 1'b1;
  logic       hi = 1'b0;
  logic       chg_en;

  int n_cmp = 0;
  int n_bad = 0;
  int tick_div = 0;
  int tick_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  chg_gate_mod #(
    .PULSE_TICKS        (PULSE),
    .TOPOFF_TICKS       (TOPOFF),
    .TRICKLE_BASE_TICKS (TBASE)
  ) i_chg_gate_mod (
    .clk            (clk),
    .rst_n          (rst_n),
    .inhibit_i      (inhibit),
    .phase_i        (phase),
    .trickle_code_i (tcode),
    .tick_i         (tick),
    .sense_lo_i     (lo),
    .sense_hi_i     (hi),
    .chg_en_o       (chg_en)
  );

  always @(negedge clk) begin
    if (tick_div == 0) begin
      tick <= 1'b0;
      tick_cnt <= 0;
    end else if (tick_cnt + 1 >= tick_div) begin
      tick <= 1'b1;
      tick_cnt <= 0;
    end else begin
      tick <= 1'b0;
      tick_cnt <= tick_cnt + 1;
    end
  end

  function automatic string vec_tag(int i);
    case (i)
      0, 4, 6, 9: return "R1";
      1, 3:       return "R3";
      2:          return "R2";
      5:          return "R4";
      default:    return "R8";
    endcase
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_high(int n, output int hits);
    hits = 0;
    for (int k = 0; k < n; k++) begin
      step();
      if (chg_en === 1'b1) hits++;
    end
  endtask

  task automatic enter(logic [1:0] ph, logic l, logic h);
    phase = 2'd0;
    step();
    lo = l;
    hi = h;
    phase = ph;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    int hits;
    int per;
    repeat (3) @(negedge clk);
    check_bit("R12 reset", chg_en, 1'b0);
    rst_n = 1'b1;
    step();
    check_bit("R1 after reset", chg_en, 1'b1);

    phase = 2'd0;
    step();
    for (int i = 0; i < 12; i++) begin
      inhibit = VEC[i][5];
      phase   = VEC[i][4:3];
      lo      = VEC[i][2];
      hi      = VEC[i][1];
      step();
      check_bit(vec_tag(i), chg_en, VEC[i][0]);
    end
    inhibit = 1'b0;

    // R5 grounded sense in fast phase, ticks running
    tick_div = 3;
    enter(2'd1, 1'b1, 1'b0);
    count_high(200, hits);
    check_int("R5 steady high", hits, 200);

    // R9 / R6 top-off with a tick every cycle
    tick_div = 1;
    enter(2'd2, 1'b1, 1'b0);
    step();
    check_bit("R9 first cycle open", chg_en, 1'b1);
    count_high(10 * TOPOFF, hits);
    check_int("R6 top-off duty", hits, 10 * PULSE);

    // R11 tick every second cycle doubles the period in cycles
    tick_div = 2;
    enter(2'd2, 1'b1, 1'b0);
    count_high(4 * TOPOFF, hits);
    count_high(20 * TOPOFF, hits);
    check_int("R11 half-rate ticks", hits, 20 * PULSE);

    // R11 no ticks: timer stays in the first window
    tick_div = 0;
    enter(2'd2, 1'b1, 1'b0);
    count_high(50, hits);
    check_int("R11 no ticks", hits, 50);

    // R7 trickle periods per code
    tick_div = 1;
    for (int c = 0; c < 4; c++) begin
      per = TBASE << c;
      tcode = 2'(c);
      enter(2'd3, 1'b1, 1'b0);
      count_high(per, hits);
      count_high(2 * per, hits);
      check_int($sformatf("R7 trickle code %0d", c), hits, 2 * PULSE);
    end

    // R10 hysteresis inside windows
    enter(2'd2, 1'b0, 1'b0);
    count_high(4 * TOPOFF, hits);
    check_int("R10 no low flag no pulse", hits, 0);
    tcode = 2'd0;
    enter(2'd3, 1'b1, 1'b1);
    count_high(2 * TBASE, hits);
    check_int("R10 high flag blocks pulse", hits, 0);

    // R8 / R9 inhibit mid-period restarts the window
    enter(2'd2, 1'b1, 1'b0);
    repeat (7) step();
    check_bit("R6 closed part", chg_en, 1'b0);
    inhibit = 1'b1;
    step();
    check_bit("R8 inhibit low", chg_en, 1'b0);
    inhibit = 1'b0;
    step();
    check_bit("R9 release reopens", chg_en, 1'b1);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

endmodule